// File: doc/BRIEF.md
# Core Power Sequencer

This block steps one core of a multi-cluster processor through the ordered power-up or power-down procedure. A request names a cluster and a core within it, and says whether the core is to come up or go down. A per-cluster flag says whether that cluster holds big cores or little cores. The block drives one bit per core for each of these: power-on reset, debug reset, trace reset, core reset, vector-unit (NEON) reset, L1 reset-disable, and power gate. It also exchanges a request/done handshake with an external power-switch ramp.

Every reset output is active low, so a value of 0 means the reset is held. Only one sequence runs at a time. Every step except the switch step waits a fixed settle count of `SETTLE` cycles. The switch step waits for the ramp to report completion. A one-cycle `done` pulse closes each sequence. A request whose index is out of range gets a one-cycle `err` pulse and nothing else happens.

Top module: `core_pwr_seq`

## Requirements
- R1: After reset, every core has all five resets held (0). Every L1 reset-disable bit is 1 and every power-gate bit is 1. `sw_req`, `busy`, `done` and `err` are all 0.
- R2: A power-up request accepted at a clock edge clears the target core's power-on reset bit at that same edge. No other output bit changes during the next `SETTLE` cycles.
- R3: On a little core (cluster flag 0), the L1 reset-disable bit is cleared `SETTLE` cycles after the power-on reset is asserted. On a big core (flag 1) that bit is never touched.
- R4: The debug reset is asserted next. On a little core this happens 2×`SETTLE` cycles after acceptance and the trace reset is asserted at the same time. On a big core it happens after `SETTLE` cycles and the trace reset is left alone.
- R5: `SETTLE` cycles after the debug reset, `sw_req` rises with `sw_on`=1 and stays high until `sw_done` is sampled high. At that same edge `sw_req` falls and the core's power-gate bit is cleared.
- R6: `SETTLE` cycles after the gate clears, the power-on reset is released. `SETTLE` cycles later the debug, core and NEON resets are released, plus the trace reset on a little core. `done` pulses for one cycle at that moment.
- R7: A request with core index ≥ `NCORE` or cluster index ≥ `NCLUST` produces a one-cycle `err` pulse in the following cycle. No output bit changes and `busy` stays 0.
- R8: A power-down sets the core's power-gate bit at acceptance. `SETTLE` cycles later it raises `sw_req` with `sw_on`=0. On `sw_done` it drops `sw_req` and pulses `done`. No reset or L1 bit changes.
- R9: Bit position `cluster*NCORE + core` of each per-core vector is the target. No other core's bits change during a sequence.
- R10: `busy` is high from acceptance until the cycle `done` pulses. Requests presented while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_up | input | 1 | 1 = power up, 0 = power down |
| req_core | input | CW | Core index within the cluster |
| req_clus | input | KW | Cluster index |
| big_core | input | NCLUST | Per-cluster core type, 1 = big |
| sw_req | output | 1 | Power-switch ramp request |
| sw_on | output | 1 | Ramp direction, 1 = open the switch |
| sw_done | input | 1 | Ramp finished |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | One-cycle rejected-request pulse |
| por_n | output | NCORE*NCLUST | Power-on reset per core, active low |
| dbg_n | output | NCORE*NCLUST | Debug reset per core, active low |
| trc_n | output | NCORE*NCLUST | Trace reset per core, active low |
| core_n | output | NCORE*NCLUST | Core reset per core, active low |
| neon_n | output | NCORE*NCLUST | Vector-unit reset per core, active low |
| l1rd | output | NCORE*NCLUST | L1 reset-disable per core |
| pgate | output | NCORE*NCLUST | Power gate per core, 1 = gated |

## Verification
The bench sweeps every core of both clusters under all four type combinations. It runs up, down, up, down on each core and compares every per-core vector in every cycle against a timeline built from the settle count and the bench's own switch latency. The second power-up starts with resets released. That run catches a design that skips asserting a reset, because such a design would leave the bit high into the switch step. It also catches one that swaps the big and little handling, because that would flip the trace or L1 bits on the wrong cores. The bench also sends out-of-range indices, which a design with a missing bound check would turn into a write on some core. It sends a stray request in the middle of a sequence, which a design that does not lock out new requests would act on, disturbing a second core.

// File: rtl/core_pwr_seq.sv
module core_pwr_seq #(
  parameter int NCORE  = 4,
  parameter int NCLUST = 2,
  parameter int SETTLE = 4,
  localparam int NC = NCORE * NCLUST,
  localparam int CW = $clog2(NCORE) + 1,
  localparam int KW = $clog2(NCLUST) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_up,
  input  logic [CW-1:0] req_core,
  input  logic [KW-1:0] req_clus,
  input  logic [NCLUST-1:0] big_core,
  output logic          sw_req,
  output logic          sw_on,
  input  logic          sw_done,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [NC-1:0] por_n,
  output logic [NC-1:0] dbg_n,
  output logic [NC-1:0] trc_n,
  output logic [NC-1:0] core_n,
  output logic [NC-1:0] neon_n,
  output logic [NC-1:0] l1rd,
  output logic [NC-1:0] pgate
);
  localparam int IW = (NC > 1) ? $clog2(NC) : 1;
  localparam int KI = (NCLUST > 1) ? $clog2(NCLUST) : 1;
  localparam int TW = $clog2(SETTLE) + 1;

  typedef enum logic [3:0] {
    S_IDLE, S_POR, S_L1, S_ARST, S_SW, S_GATE, S_PREL, S_DGATE, S_DSW
  } st_t;

  st_t           st;
  logic [TW-1:0] cnt;
  logic [IW-1:0] tgt;
  logic          big;

  wire bad = (req_core >= CW'(NCORE)) || (req_clus >= KW'(NCLUST));
  wire [IW-1:0] idx_w = IW'(32'(req_clus) * NCORE + 32'(req_core));
  wire big_w   = big_core[req_clus[KI-1:0]];
  wire settled = (cnt == TW'(SETTLE - 1));

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      tgt    <= '0;
      big    <= 1'b0;
      por_n  <= '0;
      dbg_n  <= '0;
      trc_n  <= '0;
      core_n <= '0;
      neon_n <= '0;
      l1rd   <= '1;
      pgate  <= '1;
      sw_req <= 1'b0;
      sw_on  <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      cnt  <= cnt + 1'b1;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (req_valid) begin
            if (bad) err <= 1'b1;
            else begin
              tgt <= idx_w;
              big <= big_w;
              if (req_up) begin
                por_n[idx_w] <= 1'b0;
                st <= S_POR;
              end else begin
                pgate[idx_w] <= 1'b1;
                st <= S_DGATE;
              end
            end
          end
        end
        S_POR: if (settled) begin
          cnt <= '0;
          if (!big) begin
            l1rd[tgt] <= 1'b0;
            st <= S_L1;
          end else begin
            dbg_n[tgt] <= 1'b0;
            st <= S_ARST;
          end
        end
        S_L1: if (settled) begin
          cnt <= '0;
          dbg_n[tgt] <= 1'b0;
          trc_n[tgt] <= 1'b0;
          st <= S_ARST;
        end
        S_ARST: if (settled) begin
          cnt <= '0;
          sw_req <= 1'b1;
          sw_on  <= 1'b1;
          st <= S_SW;
        end
        S_SW: if (sw_done) begin
          cnt <= '0;
          sw_req <= 1'b0;
          pgate[tgt] <= 1'b0;
          st <= S_GATE;
        end
        S_GATE: if (settled) begin
          cnt <= '0;
          por_n[tgt] <= 1'b1;
          st <= S_PREL;
        end
        S_PREL: if (settled) begin
          cnt <= '0;
          dbg_n[tgt]  <= 1'b1;
          core_n[tgt] <= 1'b1;
          neon_n[tgt] <= 1'b1;
          if (!big) trc_n[tgt] <= 1'b1;
          done <= 1'b1;
          st <= S_IDLE;
        end
        S_DGATE: if (settled) begin
          cnt <= '0;
          sw_req <= 1'b1;
          sw_on  <= 1'b0;
          st <= S_DSW;
        end
        S_DSW: if (sw_done) begin
          cnt <= '0;
          sw_req <= 1'b0;
          done <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R5
  gate_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pgate) & ~pgate) != '0) |-> ($past(sw_done) && $past(sw_req) && $past(sw_on)));

  // R6
  por_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~$past(por_n) & por_n & pgate) == '0));

  // R4
  sw_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sw_req) && sw_on) |-> (!por_n[tgt] && !dbg_n[tgt] && pgate[tgt]));

  // R8
  sw_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sw_req) && !sw_on) |-> pgate[tgt]);

  // R7
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !done));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/tb_core_pwr_seq.sv
module tb_core_pwr_seq;
  localparam int NCORE = 4, NCLUST = 2, S = 4, L = 3, NC = NCORE * NCLUST;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_up = 0, sw_done = 0;
  logic [2:0] req_core = 0;
  logic [1:0] req_clus = 0;
  logic [1:0] big_core = 0;
  logic sw_req, sw_on, busy, done, err;
  logic [NC-1:0] por_n, dbg_n, trc_n, core_n, neon_n, l1rd, pgate;
  logic [NC-1:0] e_por, e_dbg, e_trc, e_core, e_neon, e_l1, e_pg;
  int nvec = 0, nfail = 0, cyc = 0;

  always #2 clk = ~clk;

  core_pwr_seq #(.NCORE(NCORE), .NCLUST(NCLUST), .SETTLE(S)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_up(req_up),
    .req_core(req_core), .req_clus(req_clus), .big_core(big_core),
    .sw_req(sw_req), .sw_on(sw_on), .sw_done(sw_done), .busy(busy),
    .done(done), .err(err), .por_n(por_n), .dbg_n(dbg_n), .trc_n(trc_n),
    .core_n(core_n), .neon_n(neon_n), .l1rd(l1rd), .pgate(pgate));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog expired act=%0d exp<=150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cmp_vecs(input string tag);
    chk({tag, " R2 por_n R9"}, 64'(por_n), 64'(e_por));
    chk({tag, " R3 l1rd R9"}, 64'(l1rd), 64'(e_l1));
    chk({tag, " R4 dbg_n R9"}, 64'(dbg_n), 64'(e_dbg));
    chk({tag, " R4 trc_n R9"}, 64'(trc_n), 64'(e_trc));
    chk({tag, " R6 core_n R9"}, 64'(core_n), 64'(e_core));
    chk({tag, " R6 neon_n R9"}, 64'(neon_n), 64'(e_neon));
    chk({tag, " R5 pgate R9"}, 64'(pgate), 64'(e_pg));
  endtask

  task automatic seq(input bit up, input int cl, input int co, input bit stray);
    int i, n, a, m, last;
    bit lit;
    i = cl * NCORE + co;
    lit = !big_core[cl];
    n = lit ? 3 : 2;
    a = up ? n * S : S;
    m = a + L + 1;
    last = up ? m + 2 * S : m;
    req_up = up; req_clus = 2'(cl); req_core = 3'(co); req_valid = 1;
    for (int j = 0; j <= last; j++) begin
      @(negedge clk);
      if (j == 0) req_valid = 0;
      if (j == 3 && stray) req_valid = 0;
      if (up) begin
        if (j == 0) e_por[i] = 0;
        if (lit && j == S) e_l1[i] = 0;
        if (j == (n - 1) * S) begin e_dbg[i] = 0; if (lit) e_trc[i] = 0; end
        if (j == m) e_pg[i] = 0;
        if (j == m + S) e_por[i] = 1;
        if (j == last) begin
          e_dbg[i] = 1; e_core[i] = 1; e_neon[i] = 1;
          if (lit) e_trc[i] = 1;
        end
      end else if (j == 0) e_pg[i] = 1;
      cmp_vecs(up ? "up" : "down R8");
      chk("R5 sw_req", 64'(sw_req), 64'(j >= a && j < m));
      if (j >= a && j < m) chk(up ? "R5 sw_on" : "R8 sw_on", 64'(sw_on), 64'(up));
      chk("R6 done", 64'(done), 64'(j == last));
      chk("R10 busy", 64'(busy), 64'(j < last));
      chk("R7 err", 64'(err), 64'(0));
      sw_done = (j == a + L);
      if (j == 2 && stray) begin
        req_up = !up; req_clus = 2'(cl); req_core = 3'((co + 1) % NCORE); req_valid = 1;
      end
    end
  endtask

  task automatic bad_req(input int cl, input int co);
    req_up = 1; req_clus = 2'(cl); req_core = 3'(co); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R7 err pulse", 64'(err), 64'(1));
    chk("R7 busy", 64'(busy), 64'(0));
    cmp_vecs("R7 unchanged");
    @(negedge clk);
    chk("R7 err one cycle", 64'(err), 64'(0));
    chk("R7 still idle", 64'(busy), 64'(0));
    cmp_vecs("R7 unchanged");
  endtask

  initial begin
    e_por = '0; e_dbg = '0; e_trc = '0; e_core = '0; e_neon = '0;
    e_l1 = '1; e_pg = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cmp_vecs("R1 reset");
    chk("R1 sw_req", 64'(sw_req), 64'(0));
    chk("R1 busy", 64'(busy), 64'(0));
    chk("R1 done", 64'(done), 64'(0));
    chk("R1 err", 64'(err), 64'(0));
    bad_req(0, 4);
    bad_req(2, 1);
    bad_req(3, 7);
    for (int cfg = 0; cfg < 4; cfg++) begin
      big_core = 2'(cfg);
      for (int cl = 0; cl < NCLUST; cl++)
        for (int co = 0; co < NCORE; co++) begin
          seq(1, cl, co, (co == cfg));
          seq(0, cl, co, 0);
          seq(1, cl, co, 0);
          seq(0, cl, co, (co == 3 - cfg));
        end
    end
    bad_req(1, 5);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule